// File: doc/BRIEF.md
# Serial ADC Readout Controller

This block is the master side of a three-wire link to a 12-bit successive-approximation converter. The three wires are an active-low chip select, a data clock and a serial data line driven by the converter. When a start request is accepted, the block drops chip select and waits half a data-clock period with the clock low. It then runs the data clock, which comes from a divider of the system clock. The first two data-clock cycles form the converter's input sampling window, and the block ignores the data line during them. Over the next twelve cycles it samples the line on each rising edge, most significant bit first. The converter changes the line on the falling edges.

After the last bit the block waits one more half period with the clock low. It then raises chip select and presents the 12-bit word with a one-cycle valid strobe. The word is the converter's two's-complement code and is passed on unaltered. A holdoff timer sets a minimum spacing between frame starts, which keeps the conversion rate within the converter's throughput limit. Start requests are dropped while a frame or the holdoff is running, and a busy output reports this condition.

The controller is one state machine with five states. `ST_IDLE` has chip select high and waits for an accepted start. `ST_SETUP` is the half period with chip select low before the first clock rise. `ST_HIGH` and `ST_LOW` are the two halves of each data-clock period. `ST_END` is the closing half period before chip select rises. The transitions are:
- start: `ST_IDLE`→`ST_SETUP`
- first rise: `ST_SETUP`→`ST_HIGH`
- fall: `ST_HIGH`→`ST_LOW`
- rise: `ST_LOW`→`ST_HIGH`
- last fall: `ST_HIGH`→`ST_END`, after the 14th rise
- release: `ST_END`→`ST_IDLE`

Each transition other than start happens on a divider tick, once every HALF_DIV system cycles.

Top module: `adc_serial_reader`

## Requirements
- R1: While reset is asserted and right after it, cs_n_o is 1, sclk_o is 0, valid_o is 0, busy_o is 0 and result_o is 0.
- R2: A start is accepted when start_i is high and busy_o is low. cs_n_o falls in the cycle after it is accepted, with sclk_o low. The first rise of sclk_o comes HALF_DIV system cycles after that fall (4 cycles, or 32 ns, with the defaults).
- R3: sclk_o has a period of 2×HALF_DIV system cycles and is high for HALF_DIV of them. Each frame has exactly SAMPLE_CYC+DATA_W rising edges (14 with the defaults).
- R4: The data line is ignored during the first SAMPLE_CYC (2) data-clock cycles, which form the sampling window. Values driven there do not affect result_o.
- R5: sdata_i is sampled at rising edges SAMPLE_CYC+1 through SAMPLE_CYC+DATA_W. The first sampled bit becomes result_o[11] (the MSB) and the last becomes result_o[0].
- R6: result_o carries the converter's two's-complement code unaltered. 0x800 is negative full scale and 0x7FF is positive full scale.
- R7: cs_n_o rises HALF_DIV cycles after the last falling edge of sclk_o, which is 116 cycles after it fell with the defaults. sdata_i has no effect while cs_n_o is high.
- R8: valid_o is a single-cycle pulse in the first cycle that cs_n_o is high again. result_o changes only at that pulse and holds its value until the next one.
- R9: A start request made while a frame is in progress is ignored: no second frame and no extra valid pulse. busy_o is high throughout the frame.
- R10: Two frame starts are never closer than FRAME_CYC system cycles (625 with the defaults, 200 kHz at 125 MHz). A start request held high restarts exactly FRAME_CYC cycles later. Requests during the holdoff leave cs_n_o high while busy_o stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request to read one conversion |
| sdata_i | input | 1 | Serial data from the converter |
| cs_n_o | output | 1 | Active-low chip select to the converter |
| sclk_o | output | 1 | Data clock to the converter |
| result_o | output | 12 | Last complete two's-complement conversion code |
| valid_o | output | 1 | One-cycle strobe marking a new result_o |
| busy_o | output | 1 | Frame or rate holdoff in progress; starts are ignored |

## Verification
A behavioural converter model in the bench drives each bit on the falling data-clock edges. During the sampling window it drives the inverse of the coming MSB, and between frames it drives a toggling value. With that model, a result off by one position, or a result polluted by sampling-window or idle data, shows up as a wrong word. The words 0xA5A, 0x800, 0x7FF, 0x000 and 0xFFF are used. Alternating bits expose bit-order and shift-count faults, the two full-scale codes check the sign bit, and the uniform words show whether sampling-window bits leak in. Start requests are also raised in the middle of a frame, inside the holdoff, and held high continuously. These tell apart a controller that re-triggers early, one that drops a legal restart, and one that spaces frames by something other than the required period.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_HIGH,
        ST_LOW,
        ST_END
    } rd_state_t;
endpackage

// File: rtl/adc_rd_clkdiv.sv
module adc_rd_clkdiv #(
    parameter int HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic tick_o
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    logic [CW-1:0] cnt_q;

    assign tick_o = run_i && (cnt_q == CW'(HALF_DIV - 1));

    always_ff @(posedge clk) begin
        if (!rst_n || !run_i || tick_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    generate
        if (HALF_DIV > 1) begin : g_spacing
            // R3: half periods last HALF_DIV cycles, so ticks never come back to back
            a_r3_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
                tick_o |=> !tick_o);
        end
    endgenerate
endmodule

// File: rtl/adc_rd_ratelim.sv
module adc_rd_ratelim #(
    parameter int FRAME_CYC = 625
) (
    input  logic clk,
    input  logic rst_n,
    input  logic accept_i,
    output logic hold_o
);
    localparam int CW = (FRAME_CYC > 1) ? $clog2(FRAME_CYC) : 1;

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (accept_i) begin
            cnt_q <= CW'(FRAME_CYC - 1);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign hold_o = (cnt_q != '0);

    // R10: a start accepted by the controller never falls inside the holdoff
    a_r10_no_early_start: assert property (@(posedge clk) disable iff (!rst_n)
        accept_i |-> (cnt_q == '0));
endmodule

// File: rtl/adc_rd_shifter.sv
module adc_rd_shifter #(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              shift_i,
    input  logic              bit_i,
    input  logic              commit_i,
    output logic [DATA_W-1:0] result_o
);
    localparam int NW = $clog2(DATA_W + 1);

    logic [DATA_W-1:0] sreg_q;
    logic [NW-1:0]     nshift_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg_q   <= '0;
            result_o <= '0;
        end else begin
            if (shift_i) begin
                sreg_q <= {sreg_q[DATA_W-2:0], bit_i};
            end
            if (commit_i) begin
                result_o <= sreg_q;
            end
        end
    end

    // shift count since the frame began, used only by the check below
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            nshift_q <= '0;
        end else if (shift_i) begin
            nshift_q <= nshift_q + 1'b1;
        end
    end

    // R5: exactly DATA_W bits have been taken in when a word is published
    a_r5_full_word: assert property (@(posedge clk) disable iff (!rst_n)
        commit_i |-> (nshift_q == NW'(DATA_W)));
endmodule

// File: rtl/adc_serial_reader.sv
module adc_serial_reader #(
    parameter int DATA_W     = 12,
    parameter int SAMPLE_CYC = 2,
    parameter int HALF_DIV   = 4,
    parameter int FRAME_CYC  = 625
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              sdata_i,
    output logic              cs_n_o,
    output logic              sclk_o,
    output logic [DATA_W-1:0] result_o,
    output logic              valid_o,
    output logic              busy_o
);
    import adc_rd_pkg::*;

    localparam int TOTAL = SAMPLE_CYC + DATA_W;
    localparam int EW    = $clog2(TOTAL + 1);

    rd_state_t     state_q, state_d;
    logic [EW-1:0] edge_q;
    logic          tick, hold, accept, rise, shift_en, commit;

    assign accept   = (state_q == ST_IDLE) && start_i && !hold;
    assign rise     = tick && ((state_q == ST_SETUP) || (state_q == ST_LOW));
    assign shift_en = rise && (edge_q >= EW'(SAMPLE_CYC));
    assign commit   = tick && (state_q == ST_END);
    assign busy_o   = (state_q != ST_IDLE) || hold;

    adc_rd_clkdiv #(.HALF_DIV(HALF_DIV)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (state_q != ST_IDLE),
        .tick_o (tick)
    );

    adc_rd_ratelim #(.FRAME_CYC(FRAME_CYC)) u_rate (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept_i (accept),
        .hold_o   (hold)
    );

    adc_rd_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (accept),
        .shift_i  (shift_en),
        .bit_i    (sdata_i),
        .commit_i (commit),
        .result_o (result_o)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept) state_d = ST_SETUP;
            ST_SETUP: if (tick)   state_d = ST_HIGH;
            ST_HIGH:  if (tick)   state_d = (edge_q == EW'(TOTAL)) ? ST_END : ST_LOW;
            ST_LOW:   if (tick)   state_d = ST_HIGH;
            ST_END:   if (tick)   state_d = ST_IDLE;
            default:              state_d = ST_IDLE;
        endcase
    end

    // state register and rising-edge count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            edge_q  <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                edge_q <= '0;
            end else if (rise) begin
                edge_q <= edge_q + 1'b1;
            end
        end
    end

    // registered pin outputs, decoded from the next state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_n_o  <= 1'b1;
            sclk_o  <= 1'b0;
            valid_o <= 1'b0;
        end else begin
            cs_n_o  <= (state_d == ST_IDLE);
            sclk_o  <= (state_d == ST_HIGH);
            valid_o <= commit;
        end
    end

    // R2: chip select always falls with the data clock low
    a_r2_cs_fall_clk_low: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n_o) |-> !sclk_o);
    // R3: the data clock only runs inside a frame
    a_r3_clk_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_o |-> !cs_n_o);
    // R8: the strobe comes with the chip select release
    a_r8_valid_at_release: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> $rose(cs_n_o));
    // R8: the strobe lasts one cycle
    a_r8_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);
    // R9: busy is reported for the whole frame
    a_r9_busy_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n_o |-> busy_o);
endmodule

// File: tb/tb_adc_serial_reader.sv
module tb_adc_serial_reader;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        sdata_i = 1'b1;
    logic        cs_n_o, sclk_o, valid_o, busy_o;
    logic [11:0] result_o;

    int errors = 0;
    int checks = 0;
    int cyc = 0;

    // monitor / converter model state
    logic [11:0] word = 12'h000;
    logic        prev_cs = 1'b1, prev_sclk = 1'b0;
    int          t_fall = 0, t_csr = 0, t_val = 0;
    int          t_rise [0:16];
    int          rises = 0, fcnt = 0, falls_total = 0, vcount = 0;
    logic [11:0] got = 12'h000;

    adc_serial_reader dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .sdata_i  (sdata_i),
        .cs_n_o   (cs_n_o),
        .sclk_o   (sclk_o),
        .result_o (result_o),
        .valid_o  (valid_o),
        .busy_o   (busy_o)
    );

    always #4 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (cs_n_o) sdata_i = cyc[0];
        if (prev_cs && !cs_n_o) begin
            t_fall = cyc;
            rises = 0;
            fcnt = 0;
            falls_total++;
            sdata_i = !word[11];
        end
        if (!prev_sclk && sclk_o) begin
            rises++;
            if (rises <= 16) t_rise[rises] = cyc;
        end
        if (prev_sclk && !sclk_o) begin
            fcnt++;
            if (fcnt >= 2 && fcnt <= 13) sdata_i = word[13 - fcnt];
            else sdata_i = !word[11];
        end
        if (!prev_cs && cs_n_o) t_csr = cyc;
        if (valid_o) begin
            t_val = cyc;
            vcount++;
            got = result_o;
        end
        prev_cs = cs_n_o;
        prev_sclk = sclk_o;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_idle();
        while (busy_o) @(negedge clk);
    endtask

    task automatic t_reset();
        repeat (5) @(negedge clk);
        chk(cs_n_o == 1'b1, "R1 cs_n", int'(cs_n_o), 1);
        chk(sclk_o == 1'b0, "R1 sclk", int'(sclk_o), 0);
        chk(valid_o == 1'b0, "R1 valid", int'(valid_o), 0);
        chk(busy_o == 1'b0, "R1 busy", int'(busy_o), 0);
        chk(result_o == 12'h000, "R1 result", int'(result_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cs_n_o == 1'b1 && busy_o == 1'b0, "R1 after release", int'({cs_n_o, busy_o}), 2);
    endtask

    task automatic run_frame(input logic [11:0] w, input string tag);
        int vc0;
        int guard;
        wait_idle();
        word = w;
        vc0 = vcount;
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
        guard = 0;
        while (vcount == vc0 && guard < 400) begin
            @(negedge clk);
            guard++;
        end
        chk(t_rise[1] - t_fall == 4, "R2 first rise delay", t_rise[1] - t_fall, 4);
        chk(t_rise[2] - t_rise[1] == 8, "R3 clock period", t_rise[2] - t_rise[1], 8);
        chk(rises == 14, "R3 rise count", rises, 14);
        chk(t_csr - t_fall == 116, "R7 frame length", t_csr - t_fall, 116);
        chk(t_val == t_csr, "R8 valid at cs rise", t_val, t_csr);
        chk(got == w, tag, int'(got), int'(w));
        @(negedge clk);
        chk(valid_o == 1'b0, "R8 single pulse", int'(valid_o), 0);
    endtask

    task automatic t_idle_ignore();
        logic [11:0] held;
        int vc0;
        held = result_o;
        vc0 = vcount;
        repeat (200) @(negedge clk);
        chk(result_o == held, "R7 idle data ignored", int'(result_o), int'(held));
        chk(vcount == vc0, "R8 no stray valid", vcount, vc0);
    endtask

    task automatic t_mid_frame_start();
        int f0;
        int vc0;
        wait_idle();
        word = 12'h3C6;
        f0 = falls_total;
        vc0 = vcount;
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
        repeat (40) @(negedge clk);
        chk(busy_o == 1'b1, "R9 busy mid frame", int'(busy_o), 1);
        start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
        wait_idle();
        repeat (5) @(negedge clk);
        chk(falls_total == f0 + 1, "R9 one frame only", falls_total - f0, 1);
        chk(vcount == vc0 + 1, "R9 one valid only", vcount - vc0, 1);
        chk(result_o == 12'h3C6, "R9 result", int'(result_o), 'h3C6);
    endtask

    task automatic t_holdoff();
        int f0;
        int a;
        int b;
        int vc0;
        int guard;
        wait_idle();
        word = 12'h5A5;
        f0 = falls_total;
        vc0 = vcount;
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
        guard = 0;
        while (vcount == vc0 && guard < 400) begin
            @(negedge clk);
            guard++;
        end
        start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
        repeat (3) @(negedge clk);
        chk(cs_n_o == 1'b1 && falls_total == f0 + 1, "R10 start in holdoff ignored",
            falls_total - f0, 1);
        chk(busy_o == 1'b1, "R10 busy in holdoff", int'(busy_o), 1);
        // held request: spacing must be exactly the frame period
        wait_idle();
        f0 = falls_total;
        start_i = 1'b1;
        guard = 0;
        while (falls_total < f0 + 1 && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
        a = t_fall;
        while (falls_total < f0 + 2 && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
        b = t_fall;
        start_i = 1'b0;
        chk(b - a == 625, "R10 restart spacing", b - a, 625);
        wait_idle();
    endtask

    initial begin
        t_reset();
        run_frame(12'hA5A, "R5 result 0xA5A");
        run_frame(12'h800, "R6 negative full scale");
        run_frame(12'h7FF, "R6 positive full scale");
        run_frame(12'h000, "R4 zeros with window ones");
        run_frame(12'hFFF, "R4 ones with window zeros");
        t_idle_ignore();
        t_mid_frame_start();
        t_holdoff();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected=finish", cyc);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule